// File: doc/BRIEF.md
# Privilege-Banked Register File

This block holds the architectural integer registers of a CPU core: eight 32-bit data registers and eight 32-bit address registers, addressed through one 4-bit index space. The highest address register acts as the stack pointer. Two physical copies of it exist, one per privilege level, and the current privilege bit picks which copy the index reaches. Two combinational read ports and one clocked write port serve the execute stage.

The block also holds the privilege state and the interrupt mask. A status write can change both, but only while the core is in supervisor mode. A user-mode attempt to alter the interrupt mask is refused and raises a one-cycle violation flag. A separate exception-entry strobe always moves the core into supervisor mode. The current mode and mask are driven out so that user code and the surrounding core can read them.

Top module: `privreg_file`

## Requirements
- R1: While reset is asserted and after its release, every register reads zero, `sup_mode` is 1, `int_mask` is all ones (7) and `priv_viol` is 0.
- R2: Index values 0 to 7 select the data registers and 8 to 14 select address registers 0 to 6. A write with `wr_en` high stores `wr_data` at the clock edge. Both read ports return the stored value of any index, independently of each other.
- R3: Index 15 reaches the user stack pointer while `sup_mode` is 0 and the supervisor stack pointer while it is 1. A write to index 15 leaves the other copy unchanged.
- R4: When a write to index 15 and a change of mode happen on the same edge, the write lands in the stack pointer of the mode that held before that edge.
- R5: An `exc_entry` pulse makes `sup_mode` 1 from the next cycle. This holds from either mode and overrides a status write on the same edge. The mask is left as it was.
- R6: In supervisor mode, `sr_wr_en` loads `sr_wr_sup` into the mode and `sr_wr_mask` into the mask from the next cycle. Writing 0 to the mode enters user mode.
- R7: In user mode, a status write whose mask differs from `int_mask` changes neither mask nor mode. `priv_viol` is then 1 for exactly the next cycle.
- R8: In user mode, a status write with an unchanged mask has no effect and raises no violation. In particular it cannot set `sup_mode`. `priv_viol` is 0 in every cycle not covered by R7.
- R9: A read of an index being written on the same edge returns the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_wr_en | input | 1 | Status write strobe (mode and mask) |
| sr_wr_sup | input | 1 | Requested mode: 1 supervisor, 0 user |
| sr_wr_mask | input | 3 | Requested interrupt mask |
| exc_entry | input | 1 | Exception-entry strobe, forces supervisor mode |
| sup_mode | output | 1 | Current mode: 1 supervisor, 0 user |
| int_mask | output | 3 | Current interrupt mask |
| priv_viol | output | 1 | One-cycle privilege-violation flag |

## Verification
The properties assume that every input holds a known value at each sampled edge after reset. They also assume that `exc_entry` and `sr_wr_en` are plain one-cycle qualifiers, with no meaning carried across cycles. The stack-pointer readback property further assumes that no other agent writes the stack pointer between two edges. The stimulus meets all of this: the bench holds every input at a defined idle value during reset, changes inputs only just after a rising edge, and is the only writer of the block.

// File: rtl/privreg_pkg.sv
package privreg_pkg;

  localparam int DATA_W_DEF   = 32;
  localparam int NUM_DATA_DEF = 8;
  localparam int NUM_ADDR_DEF = 8;
  localparam int MASK_W_DEF   = 3;

  // privilege level held in the status state
  typedef enum logic {
    PRIV_USER  = 1'b0,
    PRIV_SUPER = 1'b1
  } priv_e;

endpackage

// File: rtl/rf_gpr_array.sv
// Flat storage for every register except the banked stack pointer.
module rf_gpr_array #(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 15,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] reg_q [NUM_GPR];
  logic [NUM_GPR-1:0] reg_en;

  genvar g;
  generate
    for (g = 0; g < NUM_GPR; g++) begin : g_reg
      // per-register clock enable from the write decode
      assign reg_en[g] = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q[g] <= '0;
        end else if (reg_en[g]) begin
          reg_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_a_data = '0;
    if (int'(rd_a_idx) < NUM_GPR) begin
      rd_a_data = reg_q[rd_a_idx];
    end
  end

  always_comb begin
    rd_b_data = '0;
    if (int'(rd_b_idx) < NUM_GPR) begin
      rd_b_data = reg_q[rd_b_idx];
    end
  end

endmodule

// File: rtl/rf_sp_bank.sv
// Two physical stack pointers, one per privilege level.
module rf_sp_bank
  import privreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  priv_e             priv_cur,
  input  logic              sp_wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sp_vis
);

  localparam int NUM_BANKS = 2;

  logic [DATA_W-1:0]    sp_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_en;
  logic                 bank_sel;

  // the mode held before the edge steers the write
  assign bank_sel = (priv_cur == PRIV_SUPER);

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_en[b] = sp_wr_en && (bank_sel == b[0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sp_q[b] <= '0;
        end else if (bank_en[b]) begin
          sp_q[b] <= wr_data;
        end
      end
    end
  endgenerate

  assign sp_vis = sp_q[bank_sel];

endmodule

// File: rtl/rf_mode_ctrl.sv
// Privilege bit, interrupt mask and violation flag.
module rf_mode_ctrl
  import privreg_pkg::*;
#(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr_en,
  input  logic              sr_wr_sup,
  input  logic [MASK_W-1:0] sr_wr_mask,
  input  logic              exc_entry,
  output priv_e             priv_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              viol_q
);

  priv_e             priv_d;
  logic [MASK_W-1:0] mask_d;
  logic              viol_d;
  logic              mask_change;

  always_comb begin
    mask_change = sr_wr_en && (sr_wr_mask != mask_q);
    viol_d      = (priv_q == PRIV_USER) && mask_change;
    priv_d      = priv_q;
    mask_d      = mask_q;
    if (sr_wr_en && (priv_q == PRIV_SUPER)) begin
      priv_d = sr_wr_sup ? PRIV_SUPER : PRIV_USER;
      mask_d = sr_wr_mask;
    end
    if (exc_entry) begin
      priv_d = PRIV_SUPER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRIV_SUPER;
      mask_q <= '1;
      viol_q <= 1'b0;
    end else begin
      priv_q <= priv_d;
      mask_q <= mask_d;
      viol_q <= viol_d;
    end
  end

endmodule

// File: rtl/privreg_file.sv
module privreg_file
  import privreg_pkg::*;
#(
  parameter int DATA_W   = DATA_W_DEF,
  parameter int NUM_DATA = NUM_DATA_DEF,
  parameter int NUM_ADDR = NUM_ADDR_DEF,
  parameter int MASK_W   = MASK_W_DEF
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [$clog2(NUM_DATA+NUM_ADDR)-1:0]      rd_a_idx,
  output logic [DATA_W-1:0]                         rd_a_data,
  input  logic [$clog2(NUM_DATA+NUM_ADDR)-1:0]      rd_b_idx,
  output logic [DATA_W-1:0]                         rd_b_data,
  input  logic                                      wr_en,
  input  logic [$clog2(NUM_DATA+NUM_ADDR)-1:0]      wr_idx,
  input  logic [DATA_W-1:0]                         wr_data,
  input  logic                                      sr_wr_en,
  input  logic                                      sr_wr_sup,
  input  logic [MASK_W-1:0]                         sr_wr_mask,
  input  logic                                      exc_entry,
  output logic                                      sup_mode,
  output logic [MASK_W-1:0]                         int_mask,
  output logic                                      priv_viol
);

  localparam int NUM_REGS = NUM_DATA + NUM_ADDR;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int SP_IDX   = NUM_REGS - 1;
  localparam int NUM_GPR  = NUM_REGS - 1;

  priv_e             priv_cur;
  logic              wr_to_sp;
  logic              gpr_wr_en;
  logic [DATA_W-1:0] gpr_a;
  logic [DATA_W-1:0] gpr_b;
  logic [DATA_W-1:0] sp_vis;

  assign wr_to_sp  = wr_en && (wr_idx == IDX_W'(SP_IDX));
  assign gpr_wr_en = wr_en && !wr_to_sp;

  rf_mode_ctrl #(.MASK_W(MASK_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_sup  (sr_wr_sup),
    .sr_wr_mask (sr_wr_mask),
    .exc_entry  (exc_entry),
    .priv_q     (priv_cur),
    .mask_q     (int_mask),
    .viol_q     (priv_viol)
  );

  rf_gpr_array #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .IDX_W(IDX_W)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (gpr_wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (gpr_a),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (gpr_b)
  );

  rf_sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_cur (priv_cur),
    .sp_wr_en (wr_to_sp),
    .wr_data  (wr_data),
    .sp_vis   (sp_vis)
  );

  assign rd_a_data = (rd_a_idx == IDX_W'(SP_IDX)) ? sp_vis : gpr_a;
  assign rd_b_data = (rd_b_idx == IDX_W'(SP_IDX)) ? sp_vis : gpr_b;
  assign sup_mode  = (priv_cur == PRIV_SUPER);

endmodule

// File: rtl/privreg_checker.sv
module privreg_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int MASK_W = 3,
  parameter int SP_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sr_wr_en,
  input logic              sr_wr_sup,
  input logic [MASK_W-1:0] sr_wr_mask,
  input logic              exc_entry,
  input logic              sup_mode,
  input logic [MASK_W-1:0] int_mask,
  input logic              priv_viol
);

  a_r5_exc_to_sup: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> sup_mode);

  a_r6_sup_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && sup_mode && !exc_entry) |=>
      (sup_mode == $past(sr_wr_sup) && int_mask == $past(sr_wr_mask)));

  a_r7_viol_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && !sup_mode && (sr_wr_mask != int_mask)) |=> priv_viol);

  a_r7_user_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_mode |=> $stable(int_mask));

  a_r8_no_spurious_viol: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_wr_en && !sup_mode && (sr_wr_mask != int_mask)) |=> !priv_viol);

  a_r8_user_no_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_mode && !exc_entry) |=> !sup_mode);

  a_r3_sp_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IDX_W'(SP_IDX) && $past(wr_en && (wr_idx == IDX_W'(SP_IDX)))
      && (sup_mode == $past(sup_mode))) |-> (rd_a_data == $past(wr_data)));

endmodule

bind privreg_file privreg_checker #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .MASK_W (MASK_W),
  .SP_IDX (SP_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .sr_wr_en   (sr_wr_en),
  .sr_wr_sup  (sr_wr_sup),
  .sr_wr_mask (sr_wr_mask),
  .exc_entry  (exc_entry),
  .sup_mode   (sup_mode),
  .int_mask   (int_mask),
  .priv_viol  (priv_viol)
);

// File: tb/sim_privreg_file.sv
`timescale 1ns/1ps
module sim_privreg_file;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, sr_wr_en, sr_wr_sup, exc_entry;
  logic [2:0]  sr_wr_mask, int_mask;
  logic        sup_mode, priv_viol;

  privreg_file u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_sup(sr_wr_sup), .sr_wr_mask(sr_wr_mask),
    .exc_entry(exc_entry),
    .sup_mode(sup_mode), .int_mask(int_mask), .priv_viol(priv_viol)
  );

  typedef struct {
    int unsigned cyc;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  logic [31:0] m_gpr [15];
  logic [31:0] m_usp, m_ssp;
  logic        m_sup, m_viol;
  logic [2:0]  m_mask;

  function automatic logic [31:0] m_read(input logic [3:0] idx);
    if (idx == 4'd15) return m_sup ? m_ssp : m_usp;
    return m_gpr[idx];
  endfunction

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.cyc = cyc; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver: one cycle of stimulus plus expectations for that cycle
  task automatic op(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                    input logic [3:0] ra, input logic [3:0] rb,
                    input logic swe, input logic ssup, input logic [2:0] smask,
                    input logic exc, input string tag);
    logic       nsup, nviol;
    logic [2:0] nmask;
    @(posedge clk); #1;
    wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    sr_wr_en = swe; sr_wr_sup = ssup; sr_wr_mask = smask;
    exc_entry = exc;
    push(0, m_read(ra), tag);
    push(1, m_read(rb), tag);
    push(2, {31'd0, m_sup}, tag);
    push(3, {29'd0, m_mask}, tag);
    push(4, {31'd0, m_viol}, tag);
    nviol = !m_sup && swe && (smask != m_mask);
    if (we) begin
      if (wi == 4'd15) begin
        if (m_sup) m_ssp = wd; else m_usp = wd;
      end else begin
        m_gpr[wi] = wd;
      end
    end
    nsup = m_sup; nmask = m_mask;
    if (swe && m_sup) begin nsup = ssup; nmask = smask; end
    if (exc) nsup = 1'b1;
    m_sup = nsup; m_mask = nmask; m_viol = nviol;
  endtask

  task automatic rd(input logic [3:0] ra, input logic [3:0] rb, input string tag);
    op(1'b0, 4'd0, 32'd0, ra, rb, 1'b0, 1'b0, 3'd0, 1'b0, tag);
  endtask

  // monitor: compare design outputs against queued expectations
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rd_a_data;
        1: act = rd_b_data;
        2: act = {31'd0, sup_mode};
        3: act = {29'd0, int_mask};
        default: act = {31'd0, priv_viol};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) m_gpr[i] = '0;
    m_usp = '0; m_ssp = '0; m_sup = 1'b1; m_mask = 3'd7; m_viol = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
    sr_wr_en = 1'b0; sr_wr_sup = 1'b0; sr_wr_mask = '0; exc_entry = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state observed while reset is held
    checks++;
    if (rd_a_data !== 32'd0 || sup_mode !== 1'b1 || int_mask !== 3'd7 || priv_viol !== 1'b0) begin
      failures++;
      $display("FAIL R1 in-reset actual=%h/%b/%h/%b expected=0/1/7/0",
               rd_a_data, sup_mode, int_mask, priv_viol);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: every register zero after release
    for (int i = 0; i < 8; i++) rd(4'(2 * i), 4'(2 * i + 1), "R1");

    // R2: fill all non-stack registers, then read back on both ports
    for (int i = 0; i < 15; i++)
      op(1'b1, 4'(i), 32'hA500_0000 + 32'(i) * 32'h0101_0101, 4'(i), 4'(14 - i),
         1'b0, 1'b0, 3'd0, 1'b0, "R2");
    for (int i = 0; i < 15; i++) rd(4'(i), 4'(14 - i), "R2");

    // R9: read of the register under write returns the old value
    op(1'b1, 4'd3, 32'hDEAD_BEEF, 4'd3, 4'd3, 1'b0, 1'b0, 3'd0, 1'b0, "R9");
    rd(4'd3, 4'd10, "R9");
    op(1'b1, 4'd12, 32'h1234_5678, 4'd12, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R9");
    rd(4'd12, 4'd12, "R9");

    // R3: supervisor stack pointer written and read
    op(1'b1, 4'd15, 32'h0000_8000, 4'd15, 4'd14, 1'b0, 1'b0, 3'd0, 1'b0, "R3");
    rd(4'd15, 4'd15, "R3");

    // R6: supervisor lowers mask, then enters user mode
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd0, 1'b1, 1'b1, 3'd2, 1'b0, "R6");
    rd(4'd15, 4'd1, "R6");
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd0, 1'b1, 1'b0, 3'd2, 1'b0, "R6");
    rd(4'd15, 4'd15, "R3");  // user copy still zero
    op(1'b1, 4'd15, 32'h0000_4000, 4'd15, 4'd8, 1'b0, 1'b0, 3'd0, 1'b0, "R3");
    rd(4'd15, 4'd15, "R3");

    // R7: user tries to change mask
    op(1'b0, 4'd0, 32'd0, 4'd0, 4'd15, 1'b1, 1'b0, 3'd5, 1'b0, "R7");
    rd(4'd0, 4'd15, "R7");
    rd(4'd0, 4'd15, "R7");
    op(1'b0, 4'd0, 32'd0, 4'd0, 4'd15, 1'b1, 1'b1, 3'd7, 1'b0, "R7");
    rd(4'd0, 4'd15, "R7");

    // R8: user write with same mask, asking for supervisor
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd1, 1'b1, 1'b1, 3'd2, 1'b0, "R8");
    rd(4'd15, 4'd1, "R8");
    rd(4'd15, 4'd1, "R8");

    // R5: exception entry from user mode
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd2, 1'b0, 1'b0, 3'd0, 1'b1, "R5");
    rd(4'd15, 4'd2, "R5");
    // R5: exception overrides a supervisor status write to user
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd2, 1'b1, 1'b0, 3'd4, 1'b1, "R5");
    rd(4'd15, 4'd2, "R5");

    // R4: stack write on the same edge as leaving supervisor mode
    op(1'b1, 4'd15, 32'h0000_9ABC, 4'd15, 4'd15, 1'b1, 1'b0, 3'd4, 1'b0, "R4");
    rd(4'd15, 4'd15, "R4");
    // R4: stack write on the same edge as exception entry from user
    op(1'b1, 4'd15, 32'h0000_4440, 4'd15, 4'd7, 1'b0, 1'b0, 3'd0, 1'b1, "R4");
    rd(4'd15, 4'd7, "R4");
    op(1'b0, 4'd0, 32'd0, 4'd15, 4'd7, 1'b1, 1'b0, 3'd4, 1'b0, "R4");
    rd(4'd15, 4'd15, "R4");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule